// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer for Code and Data

This block is the bus master of a small 8-bit controller. It talks to external memory over two byte-wide ports. The low port carries the low address byte first and a data byte afterwards. The high port carries the upper address byte. Four strobes control the transfers:

- an address-latch pulse,
- a code-fetch enable,
- a read enable,
- a write enable.

Timing is counted in oscillator clocks. A machine cycle is twelve clocks, made of six states with two phases each.

A request is a one-clock start pulse with a kind, a program address and, for data moves, a data address and a write byte. A code fetch takes one machine cycle and brings in two consecutive code bytes, one per half cycle. An external read or write takes two machine cycles. The first fetches code exactly as above. In the second, the code-fetch enable stays off and the read or write enable moves one byte at the data address. A one-clock done pulse follows the last clock of the request, and the captured bytes are then valid on the result outputs.

An external transparent latch is expected to hold the low address byte. It captures on the falling edge of the latch pulse, and the low port still drives the address for one clock after that edge.

Top module: `xbus_seq`

## Requirements
- R1: After reset, and whenever no request is running: `busy`, `done` and `ale` are low; `psen_n`, `rd_n` and `wr_n` are high; `p0_oe` is low.
- R2: A start accepted while idle sets `busy` on the next clock. Timing and completion:
  - Each machine cycle lasts 12 clocks.
  - A fetch lasts one machine cycle; a read or write lasts two.
  - `done` is high for exactly one clock, on the clock after the last one.
- R3: Each `ale` pulse is high for exactly 2 clocks. A fetch machine cycle has two pulses, at clocks 0–1 and 6–7. The data machine cycle has only one, at clocks 0–1.
- R4: The low port drives the address byte while `ale` is high and for one clock after it falls. The address seen at each `ale` fall depends on where it occurs:
  - the first half of a fetch shows the program address;
  - the second half shows the program address plus one, modulo 2^16;
  - the data machine cycle shows the data address.
- R5: The high port follows the same three addresses:
  - the program address's upper byte in clocks 0–5 of a fetch cycle;
  - the incremented address's upper byte in clocks 6–11;
  - the data address's upper byte for the whole data cycle.
- R6: In each fetch half, `psen_n` is low for 3 clocks (clocks 3–5 and 9–11) and the low port is not driven. The byte on `p0_in` in the last low clock is captured. `code_bytes` holds the second byte in bits 15:8 and the first byte in bits 7:0.
- R7: Data read (kind 2'b01):
  - `psen_n` stays high for the whole second machine cycle;
  - `rd_n` is low for clocks 3–10 of that cycle, with the low port not driven;
  - the byte present at clock 10 appears on `data_byte`.
- R8: Data write (kind 2'b10):
  - `wr_n` is low for clocks 3–10 of the second machine cycle;
  - `wdata` is driven on the low port with `p0_oe` high during clocks 3–11.
- R9: `psen_n` is never low together with `rd_n` or `wr_n`, and `rd_n` and `wr_n` are never low together.
- R10: A start pulse while `busy` is high is ignored. The running request finishes unchanged, and no further bus activity follows it.
- R11: Kind 2'b11 behaves as a fetch (kind 2'b00): one machine cycle with code strobes only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only when idle |
| kind | input | 2 | 00/11 fetch, 01 data read, 10 data write |
| pc | input | 16 | Program address of first code byte |
| daddr | input | 16 | External data address |
| wdata | input | 8 | Byte to write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| code_bytes | output | 16 | Captured code bytes {second, first} |
| data_byte | output | 8 | Byte captured by the last data read |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Code fetch enable, active low |
| rd_n | output | 1 | Data read enable, active low |
| wr_n | output | 1 | Data write enable, active low |
| p0_out | output | 8 | Low port output value |
| p0_oe | output | 1 | Low port output enable |
| p0_in | input | 8 | Low port input value |
| p2_out | output | 8 | High port (upper address byte) |

## Verification
The hardest case to reach from the ports is a second start arriving mid-request. The bench raises `start` with a different kind and address four clocks into a running fetch. It then watches fifteen idle clocks for a stray latch pulse or write strobe.

Two other corner cases come from the vector table:
- A program address of 0xFFFF forces the second-half address to wrap to 0x0000.
- An address ending in 0xFF forces the high port to change between the halves.

The bench's memory model latches the address on each `ale` fall. Every returned byte is therefore a function of the address the sequencer actually presented.

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] daddr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [2*DW-1:0] code_bytes,
  output logic [DW-1:0] data_byte,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] p0_out,
  output logic          p0_oe,
  input  logic [DW-1:0] p0_in,
  output logic [DW-1:0] p2_out
);
  localparam int MC_LEN = 12;
  localparam int HALF   = MC_LEN / 2;
  localparam logic [3:0] K_LAST = 4'(MC_LEN - 1);
  localparam logic [3:0] K_HALF = 4'(HALF);

  logic [3:0]    k;
  logic          mc;
  logic [1:0]    op;
  logic [AW-1:0] pc_q, pc1_q, da_q;
  logic [DW-1:0] wd_q;

  wire is_rd = (op == 2'b01);
  wire is_wr = (op == 2'b10);
  wire xfer  = is_rd | is_wr;
  wire fcyc  = busy & ~mc;
  wire dcyc  = busy & mc;
  wire lo_half = (k < K_HALF);
  wire [3:0] j = lo_half ? k : k - K_HALF;
  wire addr_win = busy & (lo_half | ~mc);
  wire addr_drv = addr_win & (j < 4'd3);
  wire d_win = dcyc & (k >= 4'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      k <= '0;
      mc <= 1'b0;
      op <= '0;
      pc_q <= '0;
      pc1_q <= '0;
      da_q <= '0;
      wd_q <= '0;
      code_bytes <= '0;
      data_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          k <= '0;
          mc <= 1'b0;
          op <= kind;
          pc_q <= pc;
          pc1_q <= pc + 1'b1;
          da_q <= daddr;
          wd_q <= wdata;
        end
      end else begin
        if (k == K_LAST) begin
          k <= '0;
          if (mc || !xfer) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            mc <= 1'b1;
          end
        end else begin
          k <= k + 1'b1;
        end
        if (fcyc && k == K_HALF - 1'b1) code_bytes[DW-1:0] <= p0_in;
        if (fcyc && k == K_LAST) code_bytes[2*DW-1:DW] <= p0_in;
        if (dcyc && is_rd && k == K_LAST - 1'b1) data_byte <= p0_in;
      end
    end
  end

  assign ale    = addr_win & (j < 4'd2);
  assign psen_n = ~(fcyc & (j >= 4'd3));
  assign rd_n   = ~(d_win & is_rd & (k < K_LAST));
  assign wr_n   = ~(d_win & is_wr & (k < K_LAST));
  assign p0_oe  = addr_drv | (d_win & is_wr);

  assign p0_out = addr_drv ? (mc ? da_q[DW-1:0] : (lo_half ? pc_q[DW-1:0] : pc1_q[DW-1:0]))
                : ((d_win & is_wr) ? wd_q : '0);

  assign p2_out = !busy ? '0
                : mc ? da_q[AW-1:DW]
                : lo_half ? pc_q[AW-1:DW] : pc1_q[AW-1:DW];
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic p0_oe
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ale && psen_n && rd_n && wr_n && !p0_oe));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ale_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale ##1 !ale);

  p_addr_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> p0_oe);

  p_fetch_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> !p0_oe);

  p_read_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !p0_oe);

  p_write_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> p0_oe);

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
endmodule

bind xbus_seq xbus_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ale(ale),
  .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .p0_oe(p0_oe)
);

// File: tb/xbus_seq_tb_top.sv
module xbus_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] kind = '0;
  logic [15:0] pc = '0, daddr = '0;
  logic [7:0] wdata = '0;
  logic busy, done, ale, psen_n, rd_n, wr_n, p0_oe;
  logic [15:0] code_bytes;
  logic [7:0] data_byte, p0_out, p0_in, p2_out;
  logic [15:0] lat = '0;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] codef(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] dataf(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h71;
  endfunction

  assign p0_in = !psen_n ? codef(lat) : (!rd_n ? dataf(lat) : 8'hEE);

  xbus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .pc(pc),
    .daddr(daddr), .wdata(wdata), .busy(busy), .done(done),
    .code_bytes(code_bytes), .data_byte(data_byte), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out),
    .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  localparam int NV = 6;
  localparam logic [41:0] VEC [NV] = '{
    {2'b00, 16'h1234, 16'h0000, 8'h00},
    {2'b00, 16'h80FF, 16'h0000, 8'h00},
    {2'b01, 16'h0042, 16'hBEEF, 8'h00},
    {2'b10, 16'h7FFE, 16'h0300, 8'hA5},
    {2'b01, 16'hFFFF, 16'h00C3, 8'h00},
    {2'b10, 16'h0010, 16'hFFFF, 8'h5A}
  };

  task automatic run(input logic [1:0] k_i, input logic [15:0] pc_i,
                     input logic [15:0] da_i, input logic [7:0] wd_i, input bit inject);
    int n = 0, rises = 0, ps = 0, rc = 0, wc = 0, nl = 0, excl = 0, p2bad = 0;
    logic [15:0] log0 = '0, log1 = '0, log2 = '0;
    logic [7:0] wcap = '0;
    logic ale_d = 1'b0, oe_at_fall = 1'b1;
    bit is_x = (k_i == 2'b01) || (k_i == 2'b10);
    logic [15:0] pc1 = pc_i + 16'd1;
    logic [7:0] d_before = data_byte;
    @(negedge clk);
    kind = k_i; pc = pc_i; daddr = da_i; wdata = wd_i; start = 1'b1;
    while (1) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
      end
      if (inject && n == 4) begin
        start = 1'b1; kind = 2'b10; pc = 16'hDEAD; daddr = 16'h0BAD;
      end
      if (inject && n == 5) start = 1'b0;
      if (done) break;
      if (n > 60) begin
        chk(0, "R2 watchdog", n, 25);
        break;
      end
      if (ale && !ale_d) rises++;
      if (!ale && ale_d) begin
        lat = {p2_out, p0_out};
        if (!p0_oe) oe_at_fall = 1'b0;
        if (nl == 0) log0 = lat; else if (nl == 1) log1 = lat; else log2 = lat;
        nl++;
      end
      if (n <= 6 && p2_out != pc_i[15:8]) p2bad++;
      if (n > 6 && n <= 12 && p2_out != pc1[15:8]) p2bad++;
      if (n > 12 && p2_out != da_i[15:8]) p2bad++;
      ale_d = ale;
      if (!psen_n) ps++;
      if (!rd_n) rc++;
      if (!wr_n) begin wc++; wcap = p0_out; end
      if ((!psen_n && (!rd_n || !wr_n)) || (!rd_n && !wr_n)) excl++;
    end
    chk(n == (is_x ? 25 : 13), "R2 done clock", n, is_x ? 25 : 13);
    @(negedge clk);
    chk(!done && !busy, "R2 done one clock", {done, busy}, 0);
    chk(rises == (is_x ? 3 : 2), "R3 ale pulses", rises, is_x ? 3 : 2);
    chk(oe_at_fall, "R4 low port driven at ale fall", oe_at_fall, 1);
    chk(log0 == pc_i && log1 == pc1, "R4 fetch addresses", {log0, log1}, {pc_i, pc1});
    chk(p2bad == 0, "R5 high port", p2bad, 0);
    chk(ps == 6, "R6 psen clocks", ps, 6);
    chk(code_bytes == {codef(pc1), codef(pc_i)}, "R6 code bytes", code_bytes,
        {codef(pc1), codef(pc_i)});
    chk(excl == 0, "R9 strobe exclusion", excl, 0);
    if (is_x) chk(log2 == da_i, "R4 data address", log2, da_i);
    if (k_i == 2'b01) begin
      chk(rc == 8 && wc == 0, "R7 read strobe", {rc, wc}, 8);
      chk(data_byte == dataf(da_i), "R7 read byte", data_byte, dataf(da_i));
    end else if (k_i == 2'b10) begin
      chk(wc == 8 && rc == 0, "R8 write strobe", {wc, rc}, 8);
      chk(wcap == wd_i, "R8 write byte", wcap, wd_i);
      chk(data_byte == d_before, "R8 data_byte kept", data_byte, d_before);
    end else begin
      chk(rc == 0 && wc == 0, "R11 fetch no data strobes", {rc, wc}, 0);
    end
    if (inject) begin
      int stray = 0;
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        if (ale || busy || !wr_n || !psen_n) stray++;
      end
      chk(stray == 0, "R10 start while busy ignored", stray, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ale && psen_n && rd_n && wr_n && !p0_oe, "R1 reset quiet",
        {busy, done, ale, psen_n, rd_n, wr_n, p0_oe}, 7'b0001110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !ale && psen_n && rd_n && wr_n && !p0_oe, "R1 idle after reset",
        {busy, ale, psen_n, rd_n, wr_n, p0_oe}, 6'b001110);
    for (int v = 0; v < NV; v++)
      run(VEC[v][41:40], VEC[v][39:24], VEC[v][23:8], VEC[v][7:0], 1'b0);
    run(2'b11, 16'h5A5A, 16'h1111, 8'h77, 1'b0);
    run(2'b00, 16'h2468, 16'h0000, 8'h00, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 global watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule